// File: doc/BRIEF.md
# Indirect Interrupt Routing Register Window

This block is the register front end of an I/O interrupt routing controller. Software sees two directly addressed registers: an 8-bit select register and a 32-bit data window. The select register chooses which internal register the window reaches. Through the window software reaches an identification register, a version register, an arbitration register and a table of 64-bit routing entries, one per interrupt pin. Each entry is handled as two 32-bit halves.

The block holds the routing table, the identifier and a per-pin pending bit. It tells the rest of the controller about two events. The first is a one-cycle pulse whenever a write flips an entry's mask bit. The second is a one-cycle service request whenever software rewrites an entry that is level-triggered while that pin's pending bit is set. Delivery of interrupts and end-of-interrupt handling live elsewhere.

Accesses are one cycle wide. A write is taken at the clock edge where `acc_valid` and `acc_write` are high. Read data is combinational from the current offset and state, and reading has no side effects.

Top module: `irq_regwin`

## Requirements
- R1: A write to offset 0x00 stores data bits 7:0 in the select register. A read at offset 0x00 returns the stored value, zero-extended.
- R2: With select 0x01, a window read returns (NUM_PINS−1) in bits 23:16, VERSION_CODE in bits 7:0 and zero elsewhere. Window writes with select 0x01 change nothing.
- R3: A window write with select 0x00 stores data bits 27:24 as a 4-bit identifier. Window reads with select 0x00 or 0x02 return that identifier in bits 27:24 and zero elsewhere. Window writes with select 0x02 change nothing.
- R4: A select of 0x10 or more addresses entry (select−0x10)>>1. An odd select reaches entry bits 63:32 and an even select reaches bits 31:0. Entry layout is: vector 7:0, delivery mode 10:8, destination mode 11, remote-IRR 14, trigger 15 (1 = level), mask 16, destination 63:56.
- R5: A window read of an entry index at or beyond NUM_PINS, or of a select in 0x03..0x0F, returns 0xFFFFFFFF. Window writes to those selects change no entry, and no entry aliases onto another index.
- R6: A write to an entry's lower half stores the data with bit 14 (remote-IRR) forced to 0. A write to the upper half leaves the lower half unchanged.
- R7: When a window write changes an entry's mask bit, `mask_chg_valid` is high for exactly the one cycle after the write edge, with the entry index on `mask_chg_pin` and the new mask on `mask_chg_value`. A write that leaves the mask unchanged gives no pulse.
- R8: Pending bits copy `pin_pend` at every clock edge. After a write to either half of an in-range entry whose resulting trigger bit is 1 and whose pending bit is set, `svc_req_valid` is high for the one cycle after the write edge, with the index on `svc_req_pin`. An edge-triggered entry, or a clear pending bit, gives no request.
- R9: Synchronous active-low reset clears the select register, the identifier and the pending bits, and loads every entry with only its mask bit set (lower half 0x00010000, upper half 0).
- R10: Reads at any offset other than 0x00 and 0x10 return zero, and writes there change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 8 | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the current offset |
| pin_pend | input | NUM_PINS | Pending state of each pin |
| mask_chg_valid | output | 1 | Mask-change pulse |
| mask_chg_pin | output | PIN_W | Entry whose mask changed |
| mask_chg_value | output | 1 | New mask value |
| svc_req_valid | output | 1 | Service request pulse |
| svc_req_pin | output | PIN_W | Pin needing service |

## Verification
The bench builds the block with the default 24 pins and version code 0x11, so the version word is 0x00170011. Entry 23 at selects 0x3E/0x3F is the last valid entry, and selects 0x40 through 0xFF form a wide out-of-range band. In that band, select 0x50 gives an index of 32, which a 5-bit truncation would fold onto entry 0; this makes an aliasing bug visible at the ports.

// File: rtl/irqwin_pkg.sv
// Package: shared constants and types for the interrupt routing register window.
// Assumes byte offsets are 8 bits wide and window data is 32 bits wide.
package irqwin_pkg;

    localparam logic [7:0] OFF_SELECT = 8'h00;
    localparam logic [7:0] OFF_WINDOW = 8'h10;

    localparam logic [7:0] SEL_IDENT  = 8'h00;
    localparam logic [7:0] SEL_VERS   = 8'h01;
    localparam logic [7:0] SEL_ARBIT  = 8'h02;
    localparam logic [7:0] SEL_TABLE  = 8'h10;

    localparam int BIT_RIRR = 14;
    localparam int BIT_TRIG = 15;
    localparam int BIT_MASK = 16;

    localparam logic [31:0] ENTRY_RST_LO = 32'h0001_0000;
    localparam logic [31:0] ENTRY_RST_HI = 32'h0000_0000;
    localparam logic [31:0] RIRR_CLEAR   = ~(32'h1 << BIT_RIRR);

    typedef enum logic [2:0] {
        TGT_IDENT,
        TGT_VERS,
        TGT_ARBIT,
        TGT_ENTRY,
        TGT_NONE
    } target_e;

endpackage

// File: rtl/irqwin_sel_decode.sv
// Module: irqwin_sel_decode
// Turns the select register into a target kind, an entry index and a half.
// Assumes NUM_PINS is no larger than the 120 entries an 8-bit select reaches.
module irqwin_sel_decode
    import irqwin_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic [7:0] sel,
    output target_e    tgt,
    output logic [6:0] idx,
    output logic       upper,
    output logic       in_range
);

    // Classify the select value and derive the table coordinates.
    always_comb begin
        idx      = sel[7:1] - 7'h08;
        upper    = sel[0];
        if (sel == SEL_IDENT)      tgt = TGT_IDENT;
        else if (sel == SEL_VERS)  tgt = TGT_VERS;
        else if (sel == SEL_ARBIT) tgt = TGT_ARBIT;
        else if (sel < SEL_TABLE)  tgt = TGT_NONE;
        else                       tgt = TGT_ENTRY;
        in_range = (tgt == TGT_ENTRY) && (32'(idx) < NUM_PINS);
    end

endmodule

// File: rtl/irqwin_entry.sv
// Module: irqwin_entry
// Storage for one 64-bit routing entry, written as two 32-bit halves.
// Assumes the caller qualifies wr_en with an in-range index.
module irqwin_entry
    import irqwin_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [6:0]  wr_idx,
    input  logic        wr_upper,
    input  logic [31:0] wr_data,
    output logic [31:0] lo_q,
    output logic [31:0] hi_q
);

    logic hit;
    assign hit = wr_en && (wr_idx == 7'(IDX));

    // Update the addressed half; a lower-half write drops remote-IRR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= ENTRY_RST_LO;
            hi_q <= ENTRY_RST_HI;
        end else if (hit) begin
            if (wr_upper) hi_q <= wr_data;
            else          lo_q <= wr_data & RIRR_CLEAR;
        end
    end

endmodule

// File: rtl/irqwin_redir_table.sv
// Module: irqwin_redir_table
// Holds all routing entries, serves half-entry reads and raises the
// mask-change and service-request pulses one cycle after a write edge.
// Assumes wr_en is only high for an in-range index.
module irqwin_redir_table
    import irqwin_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int PIN_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [6:0]          wr_idx,
    input  logic                wr_upper,
    input  logic [31:0]         wr_data,
    input  logic [6:0]          rd_idx,
    input  logic                rd_upper,
    output logic [31:0]         rd_data,
    input  logic [NUM_PINS-1:0] pend_q,
    output logic                mask_chg_valid,
    output logic [PIN_W-1:0]    mask_chg_pin,
    output logic                mask_chg_value,
    output logic                svc_req_valid,
    output logic [PIN_W-1:0]    svc_req_pin
);

    logic [31:0] lo_arr [NUM_PINS];
    logic [31:0] hi_arr [NUM_PINS];

    generate
        for (genvar g = 0; g < NUM_PINS; g++) begin : g_entry
            irqwin_entry #(.IDX(g)) entry_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (wr_en),
                .wr_idx   (wr_idx),
                .wr_upper (wr_upper),
                .wr_data  (wr_data),
                .lo_q     (lo_arr[g]),
                .hi_q     (hi_arr[g])
            );
        end
    endgenerate

    // Select the half-entry addressed by the read index.
    always_comb begin
        rd_data = '1;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (rd_idx == 7'(i)) rd_data = rd_upper ? hi_arr[i] : lo_arr[i];
        end
    end

    logic [31:0]      old_lo;
    logic             old_pend;
    logic [PIN_W-1:0] hit_pin;

    // Fetch the current lower half, pending bit and pin number of the write target.
    always_comb begin
        old_lo   = '0;
        old_pend = 1'b0;
        hit_pin  = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (wr_idx == 7'(i)) begin
                old_lo   = lo_arr[i];
                old_pend = pend_q[i];
                hit_pin  = PIN_W'(i);
            end
        end
    end

    logic new_mask, new_trig, mask_flip, svc_need;

    // Work out the entry's mask and trigger after this write.
    always_comb begin
        new_mask  = wr_upper ? old_lo[BIT_MASK] : wr_data[BIT_MASK];
        new_trig  = wr_upper ? old_lo[BIT_TRIG] : wr_data[BIT_TRIG];
        mask_flip = wr_en && !wr_upper && (new_mask != old_lo[BIT_MASK]);
        svc_need  = wr_en && new_trig && old_pend;
    end

    // Register the one-cycle event pulses and their payloads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_chg_valid <= 1'b0;
            mask_chg_pin   <= '0;
            mask_chg_value <= 1'b0;
            svc_req_valid  <= 1'b0;
            svc_req_pin    <= '0;
        end else begin
            mask_chg_valid <= mask_flip;
            svc_req_valid  <= svc_need;
            if (mask_flip) begin
                mask_chg_pin   <= hit_pin;
                mask_chg_value <= new_mask;
            end
            if (svc_need) svc_req_pin <= hit_pin;
        end
    end

endmodule

// File: rtl/irqwin_read_mux.sv
// Module: irqwin_read_mux
// Builds the read word for the direct offsets and the indirect window.
// Assumes the table read data already reflects the decoded entry half.
module irqwin_read_mux
    import irqwin_pkg::*;
#(
    parameter int         NUM_PINS     = 24,
    parameter logic [7:0] VERSION_CODE = 8'h11
) (
    input  logic [7:0]  offset,
    input  logic [7:0]  sel_q,
    input  target_e     tgt,
    input  logic        in_range,
    input  logic [3:0]  ident_q,
    input  logic [31:0] tbl_data,
    output logic [31:0] rdata
);

    localparam logic [7:0]  LAST_PIN  = 8'(NUM_PINS - 1);
    localparam logic [31:0] VERS_WORD = {8'h00, LAST_PIN, 8'h00, VERSION_CODE};

    logic [31:0] win_word;

    // Choose the indirect word from the decoded target.
    always_comb begin
        case (tgt)
            TGT_IDENT, TGT_ARBIT: win_word = {4'h0, ident_q, 24'h0};
            TGT_VERS:             win_word = VERS_WORD;
            TGT_ENTRY:            win_word = in_range ? tbl_data : '1;
            default:              win_word = '1;
        endcase
    end

    // Choose between the select register, the window and unmapped space.
    always_comb begin
        if (offset == OFF_SELECT)      rdata = {24'h0, sel_q};
        else if (offset == OFF_WINDOW) rdata = win_word;
        else                           rdata = '0;
    end

endmodule

// File: rtl/irq_regwin.sv
// Module: irq_regwin (top)
// Register front end of an interrupt routing controller: select register,
// data window, identifier, version, arbitration and a routing table.
// Assumes single-cycle accesses; reads are combinational and side-effect free.
module irq_regwin
    import irqwin_pkg::*;
#(
    parameter int         NUM_PINS     = 24,
    parameter logic [7:0] VERSION_CODE = 8'h11,
    parameter int         PIN_W        = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic [7:0]          acc_offset,
    input  logic [31:0]         acc_wdata,
    output logic [31:0]         acc_rdata,
    input  logic [NUM_PINS-1:0] pin_pend,
    output logic                mask_chg_valid,
    output logic [PIN_W-1:0]    mask_chg_pin,
    output logic                mask_chg_value,
    output logic                svc_req_valid,
    output logic [PIN_W-1:0]    svc_req_pin
);

    logic [7:0]          sel_q;
    logic [3:0]          ident_q;
    logic [NUM_PINS-1:0] pend_q;
    target_e             tgt;
    logic [6:0]          idx;
    logic                upper, in_range;
    logic                sel_wr, win_wr, tbl_wr;
    logic [31:0]         tbl_data;

    assign sel_wr = acc_valid && acc_write && (acc_offset == OFF_SELECT);
    assign win_wr = acc_valid && acc_write && (acc_offset == OFF_WINDOW);
    assign tbl_wr = win_wr && in_range;

    irqwin_sel_decode #(.NUM_PINS(NUM_PINS)) dec_i (
        .sel      (sel_q),
        .tgt      (tgt),
        .idx      (idx),
        .upper    (upper),
        .in_range (in_range)
    );

    // Hold the select register, identifier and pending copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            ident_q <= '0;
            pend_q  <= '0;
        end else begin
            pend_q <= pin_pend;
            if (sel_wr) sel_q <= acc_wdata[7:0];
            if (win_wr && (tgt == TGT_IDENT)) ident_q <= acc_wdata[27:24];
        end
    end

    irqwin_redir_table #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) tbl_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (tbl_wr),
        .wr_idx         (idx),
        .wr_upper       (upper),
        .wr_data        (acc_wdata),
        .rd_idx         (idx),
        .rd_upper       (upper),
        .rd_data        (tbl_data),
        .pend_q         (pend_q),
        .mask_chg_valid (mask_chg_valid),
        .mask_chg_pin   (mask_chg_pin),
        .mask_chg_value (mask_chg_value),
        .svc_req_valid  (svc_req_valid),
        .svc_req_pin    (svc_req_pin)
    );

    irqwin_read_mux #(.NUM_PINS(NUM_PINS), .VERSION_CODE(VERSION_CODE)) rmux_i (
        .offset   (acc_offset),
        .sel_q    (sel_q),
        .tgt      (tgt),
        .in_range (in_range),
        .ident_q  (ident_q),
        .tbl_data (tbl_data),
        .rdata    (acc_rdata)
    );

endmodule

// File: rtl/irqwin_chk.sv
// Module: irqwin_chk
// Property checker for irq_regwin, attached by bind below.
// Assumes the select register is visible through the bind connection.
module irqwin_chk #(
    parameter int NUM_PINS = 24
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [7:0]  acc_offset,
    input logic [7:0]  wdata_lo,
    input logic [31:0] acc_rdata,
    input logic [7:0]  sel_q,
    input logic        mask_chg_valid,
    input logic        svc_req_valid
);

    // R1
    sel_low_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_offset == 8'h00) |=> (sel_q == $past(wdata_lo)));

    // R9
    reset_sel_chk: assert property (@(posedge clk)
        !rst_n |=> (sel_q == 8'h00));

    // R2
    vers_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_offset == 8'h10 && sel_q == 8'h01) |->
        (acc_rdata[23:16] == 8'(NUM_PINS - 1) && acc_rdata[31:24] == 8'h00));

    // R7
    mask_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_chg_valid |-> $past(acc_valid && acc_write && acc_offset == 8'h10
                                 && sel_q >= 8'h10 && !sel_q[0]));

    // R8
    svc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req_valid |-> $past(acc_valid && acc_write && acc_offset == 8'h10
                                && sel_q >= 8'h10));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_offset != 8'h00 && acc_offset != 8'h10) |-> (acc_rdata == 32'h0));

endmodule

bind irq_regwin irqwin_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_valid      (acc_valid),
    .acc_write      (acc_write),
    .acc_offset     (acc_offset),
    .wdata_lo       (acc_wdata[7:0]),
    .acc_rdata      (acc_rdata),
    .sel_q          (sel_q),
    .mask_chg_valid (mask_chg_valid),
    .svc_req_valid  (svc_req_valid)
);

// File: tb/irq_regwin_tb_top.sv
// Directed bench for irq_regwin: one task per scenario.
module irq_regwin_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NPINS      = 24;
    localparam int PW         = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acc_valid = 1'b0;
    logic             acc_write = 1'b0;
    logic [7:0]       acc_offset = 8'h00;
    logic [31:0]      acc_wdata = 32'h0;
    logic [31:0]      acc_rdata;
    logic [NPINS-1:0] pin_pend = '0;
    logic             mask_chg_valid, mask_chg_value, svc_req_valid;
    logic [PW-1:0]    mask_chg_pin, svc_req_pin;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_regwin #(.NUM_PINS(NPINS), .VERSION_CODE(8'h11)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .acc_valid      (acc_valid),
        .acc_write      (acc_write),
        .acc_offset     (acc_offset),
        .acc_wdata      (acc_wdata),
        .acc_rdata      (acc_rdata),
        .pin_pend       (pin_pend),
        .mask_chg_valid (mask_chg_valid),
        .mask_chg_pin   (mask_chg_pin),
        .mask_chg_value (mask_chg_value),
        .svc_req_valid  (svc_req_valid),
        .svc_req_pin    (svc_req_pin)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] off, logic [31:0] data);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_offset = off; acc_wdata = data;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(logic [7:0] off, output logic [31:0] data);
        @(negedge clk);
        acc_offset = off;
        #(CLK_PERIOD / 4);
        data = acc_rdata;
    endtask

    task automatic rd_win(logic [7:0] sel, output logic [31:0] data);
        wr(8'h00, {24'h0, sel});
        rd(8'h10, data);
    endtask

    task automatic wr_win(logic [7:0] sel, logic [31:0] data);
        wr(8'h00, {24'h0, sel});
        wr(8'h10, data);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        rd(8'h00, v);        check("R9 select after reset", v, 32'h0);
        rd_win(8'h00, v);    check("R9 ident after reset", v, 32'h0);
        rd_win(8'h10, v);    check("R9 entry0 low after reset", v, 32'h0001_0000);
        rd_win(8'h11, v);    check("R9 entry0 high after reset", v, 32'h0);
        rd_win(8'h3E, v);    check("R9 entry23 low after reset", v, 32'h0001_0000);
        check("R9 no pulses after reset", {30'h0, mask_chg_valid, svc_req_valid}, 32'h0);
    endtask

    task automatic t_select_byte();
        logic [31:0] v;
        wr(8'h00, 32'h1234_56AB);
        rd(8'h00, v);        check("R1 select keeps low byte", v, 32'h0000_00AB);
    endtask

    task automatic t_version();
        logic [31:0] v;
        rd_win(8'h01, v);    check("R2 version word", v, 32'h0017_0011);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v);        check("R2 version ignores write", v, 32'h0017_0011);
    endtask

    task automatic t_ident();
        logic [31:0] v;
        wr_win(8'h00, 32'hA5FF_FFFF);
        rd(8'h10, v);        check("R3 ident read", v, 32'h0500_0000);
        rd_win(8'h02, v);    check("R3 arbitration read", v, 32'h0500_0000);
        wr(8'h10, 32'h0F00_0000);
        rd_win(8'h00, v);    check("R3 arbitration write ignored", v, 32'h0500_0000);
    endtask

    task automatic t_entry_halves();
        logic [31:0] v;
        wr_win(8'h12, 32'h0000_A031);
        check("R7 unmask pulse", {31'h0, mask_chg_valid}, 32'h1);
        check("R7 unmask pin", 32'(mask_chg_pin), 32'd1);
        check("R7 unmask value", {31'h0, mask_chg_value}, 32'h0);
        @(negedge clk);
        check("R7 pulse lasts one cycle", {31'h0, mask_chg_valid}, 32'h0);
        wr(8'h10, 32'h0001_A031);
        check("R7 mask pulse", {31'h0, mask_chg_valid}, 32'h1);
        check("R7 mask value", {31'h0, mask_chg_value}, 32'h1);
        wr_win(8'h13, 32'hDEAD_BEEF);
        check("R7 upper write no pulse", {31'h0, mask_chg_valid}, 32'h0);
        rd(8'h10, v);        check("R4 upper half read", v, 32'hDEAD_BEEF);
        rd_win(8'h12, v);    check("R6 lower kept by upper write", v, 32'h0001_A031);
        rd_win(8'h10, v);    check("R4 neighbour entry untouched", v, 32'h0001_0000);
    endtask

    task automatic t_remote_irr();
        logic [31:0] v;
        wr_win(8'h14, 32'h0001_4000);
        check("R7 same mask no pulse", {31'h0, mask_chg_valid}, 32'h0);
        rd(8'h10, v);        check("R6 remote-IRR forced low", v, 32'h0001_0000);
    endtask

    task automatic t_out_of_range();
        logic [31:0] v;
        rd_win(8'h40, v);    check("R5 index 24 reads ones", v, 32'hFFFF_FFFF);
        rd_win(8'hFF, v);    check("R5 select FF reads ones", v, 32'hFFFF_FFFF);
        rd_win(8'h05, v);    check("R5 select 05 reads ones", v, 32'hFFFF_FFFF);
        wr_win(8'h50, 32'h0000_0000);
        check("R5 out-of-range write no pulse", {31'h0, mask_chg_valid}, 32'h0);
        rd_win(8'h10, v);    check("R5 no alias onto entry0", v, 32'h0001_0000);
        wr_win(8'h3E, 32'h0001_0077);
        rd(8'h10, v);        check("R4 last entry writable", v, 32'h0001_0077);
    endtask

    task automatic t_service();
        pin_pend = 24'h00_0018;
        wr_win(8'h16, 32'h0001_8000);
        check("R8 level pending request", {31'h0, svc_req_valid}, 32'h1);
        check("R8 request pin", 32'(svc_req_pin), 32'd3);
        check("R7 masked level no pulse", {31'h0, mask_chg_valid}, 32'h0);
        @(negedge clk);
        check("R8 request lasts one cycle", {31'h0, svc_req_valid}, 32'h0);
        wr_win(8'h18, 32'h0001_0000);
        check("R8 edge entry no request", {31'h0, svc_req_valid}, 32'h0);
        wr_win(8'h17, 32'h1200_0000);
        check("R8 upper write of level entry", {31'h0, svc_req_valid}, 32'h1);
        pin_pend = '0;
        wr_win(8'h16, 32'h0001_8000);
        check("R8 not pending no request", {31'h0, svc_req_valid}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h00, 32'h0000_0012);
        rd(8'h20, v);        check("R10 offset 20 reads zero", v, 32'h0);
        rd(8'h04, v);        check("R10 offset 04 reads zero", v, 32'h0);
        wr(8'h20, 32'h0000_0077);
        rd(8'h00, v);        check("R10 write to 20 discarded", v, 32'h0000_0012);
        rd(8'h10, v);        check("R10 entry1 kept", v, 32'h0001_A031);
    endtask

    task automatic t_reset_again();
        logic [31:0] v;
        do_reset();
        rd(8'h00, v);        check("R9 select cleared", v, 32'h0);
        rd(8'h10, v);        check("R9 ident cleared", v, 32'h0);
        rd_win(8'h12, v);    check("R9 entry1 back to masked", v, 32'h0001_0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        t_reset_state();
        t_select_byte();
        t_version();
        t_ident();
        t_entry_halves();
        t_remote_irr();
        t_out_of_range();
        t_service();
        t_unmapped();
        t_reset_again();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule